// File: doc/BRIEF.md
# Two-Beat Split-Port Double-Rate SRAM

This block is a synchronous memory with one write-data input and a separate read-data output. Neither port is ever turned around. Every access moves a burst of two words, one word in each half of a clock cycle. A single address bus carries read and write addresses alike and accepts at most one request per cycle. A load strobe (active low) and a read/write select are taken only in the first half of the cycle. The write words and their lane enables are taken in both halves, each enable travelling with the word it qualifies. Read words come back in two half-cycle beats, with a complementary echo strobe aligned to them.

Double-edge operation is modelled with one clock, `clk2x`, running at twice the cycle rate. An internal half-cycle state machine decides whether each edge is a first-half or a second-half edge. It shows the answer on `phase_b`. The state machine has four states. `ST_A` waits for a first-half edge. On that edge it moves to `ST_B_WR` (write loaded), `ST_B_RD` (read loaded) or `ST_B_IDLE` (strobe inactive). Each of the three second-half states returns to `ST_A` on the next edge. The array is a small register file whose words are twice the port width, so one location holds a whole burst. Beat 0 maps to the low half of a location and beat 1 to the high half.

Top module: `hs_sio_sram_ddr2`

## Requirements
- R1: After reset, `rvalid` and `echo_p` are 0, `echo_n` is 1, `phase_b` is 0, and every location reads back as zero.
- R2: `phase_b` is 0 on the first edge after reset and alternates on every later edge. A value of 0 marks a first-half edge.
- R3: With `ld_n`=0 and `rw`=0 on a first-half edge, a write is loaded to location `addr`. The first-half word goes to bits [W-1:0] of the location. The word on the following second-half edge goes to bits [2W-1:W].
- R4: With W=8 there are two nibble lanes, and `wbe[i]`=1 (active high) writes bits [4i+3:4i] of that half's word. A lane whose enable is 0 keeps its old contents. Each half uses only the enables sampled with its own word. For W of 9, 18 and 36 there are 1, 2 and 4 lanes of 9 bits.
- R5: A read loaded on first-half edge t drives the low half on `rdata` from edge t+RD_LAT (default 3 edges, 1.5 cycles). It drives the high half from edge t+RD_LAT+1.
- R6: `echo_p` is 1 only while beat 0 is driven. `echo_n` is always its complement.
- R7: `rvalid` is 1 exactly during the two beats of each read.
- R8: With `ld_n`=1 on a first-half edge, the cycle is a no-op. Write data and enables are ignored and no read data is produced.
- R9: `ld_n`, `rw` and `addr` are ignored on second-half edges.
- R10: A read loaded in the cycle right after a write to the same location returns the newly merged contents.
- R11: Reads loaded in consecutive cycles produce four back-to-back valid beats, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock; two edges per access cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_n | input | 1 | Load strobe, active low, first half only |
| rw | input | 1 | 1 = read, 0 = write, first half only |
| addr | input | AW | Burst location address, first half only |
| wdata | input | W | Write word for the current half |
| wbe | input | NL | Lane write enables for the current half, active high |
| rdata | output | W | Read beat |
| rvalid | output | 1 | Read beat valid |
| echo_p | output | 1 | Echo strobe, high during beat 0 |
| echo_n | output | 1 | Complement of echo_p |
| phase_b | output | 1 | 1 when the next edge is a second-half edge |

## Verification
A write is committed on the second-half edge of its own cycle, so it is visible to a read loaded on the very next first-half edge. The bench reads it back straight away to check the merge. A read's beat 0 is due three edges after its load edge and beat 1 one edge later. The bench drives inputs and samples outputs on falling `clk2x` edges, counting those edges from the load edge: `rvalid`=0 after edge t+1, beat 0 with `echo_p`=1 after edge t+3, beat 1 with `echo_p`=0 after edge t+4, and idle after edge t+5. For back-to-back reads the second pair is due two edges after the first.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;

    typedef enum logic [1:0] {
        ST_A      = 2'd0,
        ST_B_WR   = 2'd1,
        ST_B_RD   = 2'd2,
        ST_B_IDLE = 2'd3
    } half_st_t;

    // Lane count for a given port width: nibble lanes at 8, nine-bit lanes otherwise
    function automatic int lanes_for(input int w);
        return (w == 8) ? 2 : ((w / 9) > 0 ? (w / 9) : 1);
    endfunction

endpackage

// File: rtl/hs_ctrl.sv
`timescale 1ns/1ps
module hs_ctrl #(
    parameter int AW = 4,
    parameter int W  = 8,
    parameter int NL = 2
) (
    input  logic          clk2x,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [NL-1:0] wbe,
    output logic          phase_b,
    output logic          rd_issue,
    output logic          wr_commit,
    output logic [AW-1:0] waddr,
    output logic [W-1:0]  wd_lo,
    output logic [NL-1:0] wbe_lo
);
    import hs_pkg::*;

    half_st_t st, st_nx;

    // state register
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) st <= ST_A;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = ST_A;
        unique case (st)
            ST_A:      st_nx = ld_n ? ST_B_IDLE : (rw ? ST_B_RD : ST_B_WR);
            ST_B_WR:   st_nx = ST_A;
            ST_B_RD:   st_nx = ST_A;
            ST_B_IDLE: st_nx = ST_A;
        endcase
    end

    // outputs
    always_comb begin
        phase_b   = 1'b0;
        rd_issue  = 1'b0;
        wr_commit = 1'b0;
        unique case (st)
            ST_A: begin
                phase_b  = 1'b0;
                rd_issue = !ld_n && rw;
            end
            ST_B_WR: begin
                phase_b   = 1'b1;
                wr_commit = 1'b1;
            end
            ST_B_RD:   phase_b = 1'b1;
            ST_B_IDLE: phase_b = 1'b1;
        endcase
    end

    // first-half write capture: address, beat-0 word and its enables
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            waddr  <= '0;
            wd_lo  <= '0;
            wbe_lo <= '0;
        end else if (st == ST_A && !ld_n && !rw) begin
            waddr  <= addr;
            wd_lo  <= wdata;
            wbe_lo <= wbe;
        end
    end

    AST_PHASE_FLIP:   assert property (@(posedge clk2x) disable iff (!rst_n) phase_b |=> !phase_b); // R2
    AST_PHASE_RETURN: assert property (@(posedge clk2x) disable iff (!rst_n) !phase_b |=> phase_b); // R2
    AST_COMMIT_LOADED: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!phase_b && !ld_n && !rw) |=> wr_commit); // R3
    AST_NOOP_NO_COMMIT: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!phase_b && ld_n) |=> !wr_commit); // R8

endmodule

// File: rtl/hs_array.sv
`timescale 1ns/1ps
module hs_array #(
    parameter int AW = 4,
    parameter int W  = 8,
    parameter int NL = 2
) (
    input  logic            clk2x,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [2*W-1:0]  wd2,
    input  logic [2*NL-1:0] be2,
    input  logic [AW-1:0]   raddr,
    output logic [2*W-1:0]  rd2
);
    localparam int DEPTH = 1 << AW;
    localparam int LW    = W / NL;
    localparam int W2    = 2 * W;

    logic [W2-1:0] mem [DEPTH];

    // lane-merged write; lanes of the high word follow those of the low word
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            for (int j = 0; j < 2*NL; j++) begin
                if (be2[j]) mem[waddr][j*LW +: LW] <= wd2[j*LW +: LW];
            end
        end
    end

    assign rd2 = mem[raddr];

endmodule

// File: rtl/hs_rdpipe.sv
`timescale 1ns/1ps
module hs_rdpipe #(
    parameter int W   = 8,
    parameter int LAT = 3
) (
    input  logic           clk2x,
    input  logic           rst_n,
    input  logic           issue,
    input  logic [2*W-1:0] data2,
    output logic [W-1:0]   rdata,
    output logic           rvalid,
    output logic           echo_p,
    output logic           echo_n
);
    localparam int W2 = 2 * W;

    logic [LAT-1:0] sv;
    logic [W2-1:0]  sd [LAT];
    logic [W-1:0]   hi_q;
    logic           pend;

    // latency delay line, one stage per clk2x edge
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            sv <= '0;
            for (int i = 0; i < LAT; i++) sd[i] <= '0;
        end else begin
            sv[0] <= issue;
            sd[0] <= data2;
            for (int i = 1; i < LAT; i++) begin
                sv[i] <= sv[i-1];
                sd[i] <= sd[i-1];
            end
        end
    end

    // beat serializer: low half first, high half on the next edge
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            hi_q   <= '0;
            pend   <= 1'b0;
            rvalid <= 1'b0;
            echo_p <= 1'b0;
        end else if (sv[LAT-1]) begin
            rdata  <= sd[LAT-1][W-1:0];
            hi_q   <= sd[LAT-1][W2-1:W];
            pend   <= 1'b1;
            rvalid <= 1'b1;
            echo_p <= 1'b1;
        end else if (pend) begin
            rdata  <= hi_q;
            pend   <= 1'b0;
            rvalid <= 1'b1;
            echo_p <= 1'b0;
        end else begin
            rvalid <= 1'b0;
            echo_p <= 1'b0;
        end
    end

    assign echo_n = ~echo_p;

    initial AST_LAT_MIN: assert (LAT >= 1); // R5
    AST_ECHO_IN_VALID: assert property (@(posedge clk2x) disable iff (!rst_n) echo_p |-> rvalid); // R6
    AST_BEAT_PAIR:     assert property (@(posedge clk2x) disable iff (!rst_n) echo_p |=> (rvalid && !echo_p)); // R5
    AST_NO_LONE_BEAT:  assert property (@(posedge clk2x) disable iff (!rst_n)
        (rvalid && !echo_p) |-> $past(echo_p)); // R7

endmodule

// File: rtl/hs_sio_sram_ddr2.sv
`timescale 1ns/1ps
module hs_sio_sram_ddr2 #(
    parameter int AW     = 4,
    parameter int W      = 8,
    parameter int RD_LAT = 3,
    localparam int NL    = hs_pkg::lanes_for(W)
) (
    input  logic          clk2x,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [NL-1:0] wbe,
    output logic [W-1:0]  rdata,
    output logic          rvalid,
    output logic          echo_p,
    output logic          echo_n,
    output logic          phase_b
);
    logic          rd_issue, wr_commit;
    logic [AW-1:0] waddr;
    logic [W-1:0]  wd_lo;
    logic [NL-1:0] wbe_lo;
    logic [2*W-1:0] rd2;

    hs_ctrl #(.AW(AW), .W(W), .NL(NL)) u_ctrl (
        .clk2x(clk2x), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .wdata(wdata), .wbe(wbe), .phase_b(phase_b), .rd_issue(rd_issue),
        .wr_commit(wr_commit), .waddr(waddr), .wd_lo(wd_lo), .wbe_lo(wbe_lo)
    );

    hs_array #(.AW(AW), .W(W), .NL(NL)) u_array (
        .clk2x(clk2x), .rst_n(rst_n), .we(wr_commit), .waddr(waddr),
        .wd2({wdata, wd_lo}), .be2({wbe, wbe_lo}), .raddr(addr), .rd2(rd2)
    );

    hs_rdpipe #(.W(W), .LAT(RD_LAT)) u_rdpipe (
        .clk2x(clk2x), .rst_n(rst_n), .issue(rd_issue), .data2(rd2),
        .rdata(rdata), .rvalid(rvalid), .echo_p(echo_p), .echo_n(echo_n)
    );

    AST_ONE_REQ_PER_CYCLE: assert property (@(posedge clk2x) disable iff (!rst_n) rd_issue |=> !rd_issue); // R11
    AST_NO_RD_WR_CLASH:    assert property (@(posedge clk2x) disable iff (!rst_n) !(rd_issue && wr_commit)); // R3

endmodule

// File: tb/sim_hs_sio_sram_ddr2.sv
`timescale 1ns/1ps
module sim_hs_sio_sram_ddr2;
    logic       clk2x = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_n = 1'b1, rw = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [1:0] wbe = '0;
    logic [7:0] rdata;
    logic       rvalid, echo_p, echo_n, phase_b;

    int checks = 0, errs = 0;
    logic [15:0] model [16];

    // {addr, d0, be0, d1, be1}
    localparam logic [23:0] TBL [6] = '{
        {4'd3,  8'hA5, 2'b11, 8'h3C, 2'b11},
        {4'd3,  8'hF0, 2'b01, 8'h0F, 2'b10},
        {4'd7,  8'h12, 2'b10, 8'h34, 2'b01},
        {4'd15, 8'hFF, 2'b00, 8'hEE, 2'b00},
        {4'd0,  8'h81, 2'b11, 8'h7E, 2'b11},
        {4'd15, 8'h9C, 2'b11, 8'hC9, 2'b01}
    };

    hs_sio_sram_ddr2 u0 (
        .clk2x(clk2x), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .wdata(wdata), .wbe(wbe), .rdata(rdata), .rvalid(rvalid),
        .echo_p(echo_p), .echo_n(echo_n), .phase_b(phase_b)
    );

    always #10 clk2x = ~clk2x;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // One access cycle, starting and ending just after a falling edge with phase_b==0.
    // Second half drives an altered address and b_ld, which must be ignored (R9).
    task automatic op(input logic a_ld, input logic a_rw, input logic [3:0] a,
                      input logic [7:0] d0, input logic [1:0] b0,
                      input logic [7:0] d1, input logic [1:0] b1, input logic b_ld);
        ld_n = a_ld; rw = a_rw; addr = a; wdata = d0; wbe = b0;
        @(posedge clk2x); @(negedge clk2x);
        ld_n = b_ld; addr = a ^ 4'hF; wdata = d1; wbe = b1;
        @(posedge clk2x); @(negedge clk2x);
        ld_n = 1'b1;
    endtask

    task automatic model_wr(input logic [3:0] a, input logic [7:0] d0, input logic [1:0] b0,
                            input logic [7:0] d1, input logic [1:0] b1);
        for (int l = 0; l < 2; l++) begin
            if (b0[l]) model[a][l*4 +: 4] = d0[l*4 +: 4];
            if (b1[l]) model[a][8 + l*4 +: 4] = d1[l*4 +: 4];
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d0, input logic [1:0] b0,
                      input logic [7:0] d1, input logic [1:0] b1);
        op(1'b0, 1'b0, a, d0, b0, d1, b1, 1'b1);
        model_wr(a, d0, b0, d1, b1);
    endtask

    task automatic rd_check(input logic [3:0] a, input string req);
        op(1'b0, 1'b1, a, 8'h00, 2'b00, 8'h00, 2'b00, 1'b1);
        chk(rvalid == 1'b0, "R5 early", {15'd0, rvalid}, 16'd0);
        op(1'b1, 1'b0, 4'd0, 8'h00, 2'b00, 8'h00, 2'b00, 1'b1);
        chk(rvalid && rdata == model[a][7:0], req, {rvalid, 7'd0, rdata}, {1'b1, 7'd0, model[a][7:0]});
        chk(echo_p && !echo_n, "R6 beat0", {14'd0, echo_p, echo_n}, 16'h2);
        @(posedge clk2x); @(negedge clk2x);
        chk(rvalid && rdata == model[a][15:8], req, {rvalid, 7'd0, rdata}, {1'b1, 7'd0, model[a][15:8]});
        chk(!echo_p && echo_n, "R6 beat1", {14'd0, echo_p, echo_n}, 16'h1);
        @(posedge clk2x); @(negedge clk2x);
        chk(!rvalid && !echo_p, "R7 idle", {14'd0, rvalid, echo_p}, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk2x);
        checks++; errs++;
        $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk2x);
        rst_n = 1'b1;
        // R1: reset state
        chk(!rvalid && !echo_p && echo_n, "R1", {13'd0, rvalid, echo_p, echo_n}, 16'h1);
        chk(phase_b == 1'b0, "R2 first", {15'd0, phase_b}, 16'd0);
        @(posedge clk2x); @(negedge clk2x);
        chk(phase_b == 1'b1, "R2 second", {15'd0, phase_b}, 16'd1);
        @(posedge clk2x); @(negedge clk2x);
        chk(phase_b == 1'b0, "R2 back", {15'd0, phase_b}, 16'd0);
        for (int a = 0; a < 16; a++) rd_check(a[3:0], "R1 zero");

        // table walk: write then read back in the very next cycle
        for (int k = 0; k < 6; k++) begin
            wr(TBL[k][23:20], TBL[k][19:12], TBL[k][11:10], TBL[k][9:2], TBL[k][1:0]);
            rd_check(TBL[k][23:20], "R3,R4,R10 rd-after-wr");
        end

        // R8: inactive strobe, data and enables present
        op(1'b1, 1'b0, 4'd3, 8'hFF, 2'b11, 8'hFF, 2'b11, 1'b1);
        chk(!rvalid, "R8 no read", {15'd0, rvalid}, 16'd0);
        op(1'b1, 1'b1, 4'd3, 8'h00, 2'b00, 8'h00, 2'b00, 1'b1);
        chk(!rvalid, "R8 no read", {15'd0, rvalid}, 16'd0);
        rd_check(4'd3, "R8 unchanged");

        // R9: strobe asserted only in the second half
        op(1'b1, 1'b0, 4'd7, 8'h66, 2'b11, 8'h99, 2'b11, 1'b0);
        rd_check(4'd7, "R9 unchanged");
        rd_check(4'd8, "R9 unchanged");

        // R11: consecutive reads
        op(1'b0, 1'b1, 4'd0, 8'h00, 2'b00, 8'h00, 2'b00, 1'b1);
        op(1'b0, 1'b1, 4'd7, 8'h00, 2'b00, 8'h00, 2'b00, 1'b1);
        chk(rvalid && echo_p && rdata == model[0][7:0], "R11 a lo", {rvalid, echo_p, 6'd0, rdata}, {2'b11, 6'd0, model[0][7:0]});
        @(posedge clk2x); @(negedge clk2x);
        chk(rvalid && !echo_p && rdata == model[0][15:8], "R11 a hi", {rvalid, echo_p, 6'd0, rdata}, {2'b10, 6'd0, model[0][15:8]});
        @(posedge clk2x); @(negedge clk2x);
        chk(rvalid && echo_p && rdata == model[7][7:0], "R11 b lo", {rvalid, echo_p, 6'd0, rdata}, {2'b11, 6'd0, model[7][7:0]});
        @(posedge clk2x); @(negedge clk2x);
        chk(rvalid && !echo_p && rdata == model[7][15:8], "R11 b hi", {rvalid, echo_p, 6'd0, rdata}, {2'b10, 6'd0, model[7][15:8]});
        @(posedge clk2x); @(negedge clk2x);
        chk(!rvalid, "R7 after pair", {15'd0, rvalid}, 16'd0);

        finish_run();
    end
endmodule